// File: doc/BRIEF.md
# Single-Precision Quiet Comparator

This block compares two IEEE-754 binary32 operands. It presents the outcome as a 32-bit result word. The low four bits hold a one-hot relation code: less, equal, greater or unordered. Two further bits report, for each operand, whether it is subnormal. Subnormal inputs keep their full value, so a tiny subnormal still orders above zero. Signed zeros compare equal. Infinities order beyond every finite value.

Alongside the word, the block raises an invalid-operation indication when either operand is a signaling NaN. A quiet NaN makes the result unordered but raises nothing. The invalid indication is meant to feed an external flag register, which is not part of this block.

Operands are accepted on a valid strobe. The result word and the invalid indication appear one clock later with their own valid strobe. They keep their value until the next accepted pair.

Top module: `fcmp_quiet_unit`

## Requirements
- R1: `res_valid` is high in exactly the cycle after a cycle with `in_valid` high. The result is registered once. Reset (active-low, asynchronous) clears `res_valid`, `res_word` and `res_invalid`.
- R2: Bit 0 of `res_word` is set when operand A is numerically less than operand B and neither is NaN.
- R3: Bit 1 of `res_word` is set when the operands are numerically equal. +0 and -0 count as equal.
- R4: Bit 2 of `res_word` is set when A is numerically greater than B and neither is NaN.
- R5: Bit 3 of `res_word` is set when either operand is a NaN (exponent all ones, fraction nonzero). Bits 0 to 2 are then clear.
- R6: Exactly one of bits 3..0 of `res_word` is set, and bits 31..6 are zero.
- R7: Bit 4 is set when A is subnormal (exponent zero, fraction nonzero), and bit 5 is set when B is subnormal. Zeros are not subnormal.
- R8: Subnormal operands are compared at their full value and not flushed. The smallest positive subnormal is greater than +0, and its negative is less than -0.
- R9: `res_invalid` is set when either operand is a signaling NaN, that is a NaN whose fraction bit 22 is zero. A quiet NaN (fraction bit 22 set) leaves it clear.
- R10: -infinity is less than every other non-NaN value, +infinity is greater than every other non-NaN value, and an infinity equals itself.
- R11: While `in_valid` is low, `res_word` and `res_invalid` keep their last value, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is valid this cycle |
| op_a | input | 32 | Operand A, binary32 |
| op_b | input | 32 | Operand B, binary32 |
| res_valid | output | 1 | Result valid, one cycle after `in_valid` |
| res_word | output | 32 | Relation code in bits 3..0, subnormal flags in bits 5..4 |
| res_invalid | output | 1 | A signaling NaN was among the operands |

## Verification
Random operand pairs are drawn from six classes: signed zeros, subnormals, infinities, quiet NaNs, signaling NaNs and normal numbers. The B operand is often derived from A, as an exact copy, a sign-flipped copy or a neighbour one unit away. Copies and sign flips separate equality from the signed ordering. Neighbours expose off-by-one faults in the magnitude compare. Class pairs such as zero against subnormal or infinity against finite catch any flushing or wrong treatment of special values. Quiet and signaling NaNs are given separately, so that the unordered code and the invalid indication can each be told apart. Idle cycles with changing operands show whether the registered result leaks through.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  // Positions of the fields inside the result word.
  localparam int unsigned REL_LT_BIT   = 0;
  localparam int unsigned REL_EQ_BIT   = 1;
  localparam int unsigned REL_GT_BIT   = 2;
  localparam int unsigned REL_UN_BIT   = 3;
  localparam int unsigned SUB_A_BIT    = 4;
  localparam int unsigned SUB_B_BIT    = 5;
  localparam int unsigned REL_W        = 4;
  localparam int unsigned USED_RES_W   = 6;

  // Class of one operand, derived from its fields.
  typedef struct packed {
    logic sign;
    logic is_zero;
    logic is_sub;
    logic is_inf;
    logic is_nan;
    logic is_snan;
  } fp_class_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned OP_W = 1 + EXP_W + MAN_W
) (
  input  logic [OP_W-1:0] word,
  output fp_class_t       cls
);

  localparam int unsigned QUIET_BIT = MAN_W - 1;

  logic [EXP_W-1:0] exp_field;
  logic [MAN_W-1:0] frac_field;
  logic             exp_all_ones;
  logic             exp_all_zero;
  logic             frac_nonzero;

  assign exp_field    = word[OP_W-2:MAN_W];
  assign frac_field   = word[MAN_W-1:0];
  assign exp_all_ones = &exp_field;
  assign exp_all_zero = ~|exp_field;
  assign frac_nonzero = |frac_field;

  always_comb begin
    cls.sign    = word[OP_W-1];
    cls.is_zero = exp_all_zero & ~frac_nonzero;
    cls.is_sub  = exp_all_zero &  frac_nonzero;
    cls.is_inf  = exp_all_ones & ~frac_nonzero;
    cls.is_nan  = exp_all_ones &  frac_nonzero;
    cls.is_snan = exp_all_ones &  frac_nonzero & ~frac_field[QUIET_BIT];
  end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int unsigned OP_W = 32
) (
  input  logic [OP_W-1:0]  word_a,
  input  logic [OP_W-1:0]  word_b,
  input  fp_class_t        cls_a,
  input  fp_class_t        cls_b,
  output logic [REL_W-1:0] rel_onehot
);

  // Maps a sign-magnitude value onto an unsigned key with the same
  // numeric order; both zeros share one key.
  function automatic logic [OP_W-1:0] order_key(input logic [OP_W-1:0] w,
                                                input logic            zero);
    logic [OP_W-1:0] top_bit;
    top_bit = {1'b1, {(OP_W-1){1'b0}}};
    if (zero)
      return top_bit;
    else if (w[OP_W-1])
      return ~w;
    else
      return w | top_bit;
  endfunction

  logic [OP_W-1:0] key_a;
  logic [OP_W-1:0] key_b;
  logic            unordered;
  logic            key_lt;
  logic            key_eq;

  assign key_a     = order_key(word_a, cls_a.is_zero);
  assign key_b     = order_key(word_b, cls_b.is_zero);
  assign unordered = cls_a.is_nan | cls_b.is_nan;
  assign key_lt    = key_a < key_b;
  assign key_eq    = key_a == key_b;

  always_comb begin
    rel_onehot             = '0;
    rel_onehot[REL_UN_BIT] = unordered;
    rel_onehot[REL_LT_BIT] = ~unordered & key_lt;
    rel_onehot[REL_EQ_BIT] = ~unordered & key_eq;
    rel_onehot[REL_GT_BIT] = ~unordered & ~key_lt & ~key_eq;
  end

endmodule

// File: rtl/fcmp_exc.sv
module fcmp_exc
  import fcmp_pkg::*;
(
  input  fp_class_t cls_a,
  input  fp_class_t cls_b,
  output logic      invalid
);

  // Only signaling NaNs raise invalid in a quiet compare.
  assign invalid = cls_a.is_snan | cls_b.is_snan;

endmodule

// File: rtl/fcmp_quiet_unit.sv
module fcmp_quiet_unit
  import fcmp_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  parameter int unsigned RES_W = 32,
  localparam int unsigned OP_W = 1 + EXP_W + MAN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  output logic             res_valid,
  output logic [RES_W-1:0] res_word,
  output logic             res_invalid
);

  logic [1:0][OP_W-1:0] operands;
  fp_class_t            cls [2];
  fp_class_t            cls_a;
  fp_class_t            cls_b;
  logic [REL_W-1:0]     rel_next;
  logic                 invalid_next;
  logic [RES_W-1:0]     word_next;

  assign operands[0] = op_a;
  assign operands[1] = op_b;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fcmp_classify #(
      .EXP_W(EXP_W),
      .MAN_W(MAN_W)
    ) u_cls (
      .word(operands[g]),
      .cls (cls[g])
    );
  end

  assign cls_a = cls[0];
  assign cls_b = cls[1];

  fcmp_order #(
    .OP_W(OP_W)
  ) u_order (
    .word_a    (op_a),
    .word_b    (op_b),
    .cls_a     (cls_a),
    .cls_b     (cls_b),
    .rel_onehot(rel_next)
  );

  fcmp_exc u_exc (
    .cls_a  (cls_a),
    .cls_b  (cls_b),
    .invalid(invalid_next)
  );

  always_comb begin
    word_next                  = '0;
    word_next[REL_W-1:0]       = rel_next;
    word_next[SUB_A_BIT]       = cls_a.is_sub;
    word_next[SUB_B_BIT]       = cls_b.is_sub;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_word    <= '0;
      res_invalid <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_word    <= word_next;
        res_invalid <= invalid_next;
      end
    end
  end

endmodule

// File: rtl/fcmp_quiet_unit_sva.sv
module fcmp_quiet_unit_sva
  import fcmp_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  parameter int unsigned RES_W = 32,
  localparam int unsigned OP_W = 1 + EXP_W + MAN_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [OP_W-1:0]  op_a,
  input logic [OP_W-1:0]  op_b,
  input logic             res_valid,
  input logic [RES_W-1:0] res_word,
  input logic             res_invalid,
  input logic [REL_W-1:0] rel_next
);

  function automatic logic nan_of(input logic [OP_W-1:0] w);
    return (&w[OP_W-2:MAN_W]) && (|w[MAN_W-1:0]);
  endfunction

  function automatic logic snan_of(input logic [OP_W-1:0] w);
    return nan_of(w) && !w[MAN_W-1];
  endfunction

  function automatic logic sub_of(input logic [OP_W-1:0] w);
    return (w[OP_W-2:MAN_W] == '0) && (|w[MAN_W-1:0]);
  endfunction

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);

  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);

  p_zero_pair_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_a[OP_W-2:0] == '0 && op_b[OP_W-2:0] == '0) |=> res_word[REL_EQ_BIT]);

  p_nan_unordered_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (nan_of(op_a) || nan_of(op_b))) |=> res_word[REL_UN_BIT]);

  p_single_relation_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $countones(res_word[REL_W-1:0]) == 1);

  p_next_relation_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rel_next) == 1);

  p_upper_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_word[RES_W-1:USED_RES_W] == '0);

  p_sub_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (res_word[SUB_A_BIT] == sub_of($past(op_a)))
              && (res_word[SUB_B_BIT] == sub_of($past(op_b))));

  p_snan_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_invalid == (snan_of($past(op_a)) || snan_of($past(op_b))));

  p_invalid_unordered_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_invalid |-> res_word[REL_UN_BIT]);

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_word) && $stable(res_invalid));

endmodule

bind fcmp_quiet_unit fcmp_quiet_unit_sva #(
  .EXP_W(EXP_W),
  .MAN_W(MAN_W),
  .RES_W(RES_W)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .op_a       (op_a),
  .op_b       (op_b),
  .res_valid  (res_valid),
  .res_word   (res_word),
  .res_invalid(res_invalid),
  .rel_next   (rel_next)
);

// File: tb/fcmp_quiet_unit_test.sv
`timescale 1ns/1ps
module fcmp_quiet_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        res_valid;
  logic [31:0] res_word;
  logic        res_invalid;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;

  always #2.5 clk = ~clk;

  fcmp_quiet_unit uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_a       (op_a),
    .op_b       (op_b),
    .res_valid  (res_valid),
    .res_word   (res_word),
    .res_invalid(res_invalid)
  );

  // ---------- bench model: sign-magnitude reasoning ----------
  function automatic bit is_nan(input logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] != 0);
  endfunction

  function automatic bit is_snan(input logic [31:0] w);
    return is_nan(w) && (w[22] == 1'b0);
  endfunction

  function automatic bit is_sub(input logic [31:0] w);
    return (w[30:23] == 8'h00) && (w[22:0] != 0);
  endfunction

  // 1=lt 2=eq 4=gt 8=unordered
  function automatic logic [3:0] model_rel(input logic [31:0] a, input logic [31:0] b);
    if (is_nan(a) || is_nan(b)) return 4'b1000;
    if (a[30:0] == 0 && b[30:0] == 0) return 4'b0010;
    if (a[31] != b[31]) return a[31] ? 4'b0001 : 4'b0100;
    if (a[30:0] == b[30:0]) return 4'b0010;
    if ((a[30:0] > b[30:0]) ^ a[31]) return 4'b0100;
    return 4'b0001;
  endfunction

  function automatic string rel_tag(input logic [3:0] r);
    case (r)
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0100: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Applies one pair; the result is registered at the following rising edge
  // and sampled at the falling edge after it.
  task automatic apply(input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [3:0]  er;
    logic [31:0] ew;
    string       t;
    er = model_rel(a, b);
    ew = {26'd0, is_sub(b), is_sub(a), er};
    t  = (tag == "") ? rel_tag(er) : tag;
    @(negedge clk);
    in_valid = 1'b1;
    op_a = a;
    op_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check(res_valid == 1'b1, "R1 res_valid", {31'd0, res_valid}, 32'd1);
    check(res_word[3:0] == er, t, {28'd0, res_word[3:0]}, {28'd0, er});
    check(res_word[5:4] == ew[5:4], "R7 subnormal bits", {30'd0, res_word[5:4]}, {30'd0, ew[5:4]});
    check(res_word[31:6] == 0 && $countones(res_word[3:0]) == 1, "R6 shape",
          res_word, ew);
    check(res_invalid == (is_snan(a) || is_snan(b)), "R9 invalid",
          {31'd0, res_invalid}, {31'd0, (is_snan(a) || is_snan(b))});
  endtask

  // Idle cycle with changed operands: outputs must not move.
  task automatic idle_probe(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] w0;
    logic        i0;
    w0 = res_word;
    i0 = res_invalid;
    op_a = a;
    op_b = b;
    @(negedge clk);
    check(res_valid == 1'b0, "R1 idle valid", {31'd0, res_valid}, 32'd0);
    check(res_word == w0 && res_invalid == i0, "R11 hold", res_word, w0);
  endtask

  function automatic logic [31:0] rand_op();
    logic [31:0] r;
    logic        s;
    r = $urandom;
    s = r[31];
    case ($urandom % 8)
      0: return {s, 31'd0};
      1: return {s, 8'h00, (r[22:0] == 0) ? 23'd1 : r[22:0]};
      2: return {s, 8'hFF, 23'd0};
      3: return {s, 8'hFF, 1'b1, r[21:0]};
      4: return {s, 8'hFF, 1'b0, (r[21:0] == 0) ? 22'd5 : r[21:0]};
      default: return {s, 8'(1 + ($urandom % 254)), r[22:0]};
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL R1 watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : stim
    int unsigned seed_sink;
    seed_sink = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check(res_valid == 0 && res_word == 0 && res_invalid == 0, "R1 reset",
          res_word, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    apply(32'h3F800000, 32'h40000000, "R2 one<two");
    apply(32'h40000000, 32'h3F800000, "R4 two>one");
    apply(32'hC0000000, 32'hBF800000, "R2 neg order");
    apply(32'h00000000, 32'h80000000, "R3 +0==-0");
    apply(32'h00000001, 32'h00000000, "R8 sub>+0");
    apply(32'h80000001, 32'h80000000, "R8 -sub<-0");
    apply(32'h00000002, 32'h00000001, "R8 sub order");
    apply(32'h00400000, 32'h80400000, "R7 both sub");
    apply(32'hFF800000, 32'hFF7FFFFF, "R10 -inf low");
    apply(32'h7F800000, 32'h7F7FFFFF, "R10 +inf high");
    apply(32'h7F800000, 32'h7F800000, "R10 inf equal");
    apply(32'h7FC00000, 32'h3F800000, "R5 qnan");
    apply(32'h7F800001, 32'h3F800000, "R9 snan a");
    apply(32'h00000000, 32'hFFA00000, "R9 snan b");
    apply(32'hFFC00001, 32'h7FC00000, "R9 quiet pair");
    idle_probe(32'h7F800001, 32'h00000001);
    apply(32'h12345678, 32'h12345678, "R3 same");
    idle_probe(32'hFFFFFFFF, 32'h00000000);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [31:0] b;
      a = rand_op();
      case ($urandom % 5)
        0: b = a;
        1: b = a ^ 32'h80000000;
        2: b = a + 32'd1;
        3: b = a - 32'd1;
        default: b = rand_op();
      endcase
      apply(a, b, "");
      if (i % 37 == 0) idle_probe(rand_op(), rand_op());
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule